// File: doc/BRIEF.md
# Bit-Serial Clock Port Command Engine

This block sits behind a small register write port and turns software bit-banging into a serial command exchange with a calendar clock. Three 16-bit registers are visible at fixed offsets: a line register carrying a clock bit (bit 0), a data bit (bit 1) and a select bit (bit 2); a direction register whose bit 1 says which way data moves; and an enable register whose bit 0 routes line writes. Software opens a command with a fixed two-write handshake, then clocks in an 8-bit command code. Depending on the code, the block either answers with one, three or seven bytes, or takes in one status byte.

Time of day arrives on a bus of plain binary fields: years since a base year, a 0-based month, day of month, a 0-based weekday (Sunday is 0), hour, minute and second. When a time command completes, the block freezes a BCD copy of these fields and serializes it. Software reads the line register back through a readback port and polls bit 1 to collect each reply bit.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset the line register reads 0 and the block is asleep; the first write to offset 0xC4 wakes it to idle whatever the enable register holds.
- R2: While enable bit 0 is 0, a write to 0xC4 leaves the line register unchanged and is stored into the enable register instead.
- R3: When the stored line register has bit 2 at 0, a write to 0xC4 keeps the old bit 1 in place of the written bit 1.
- R4: Idle, line register 0x0001 and an incoming line value of 0x0005 open the command phase; the line register then reads 0x0005.
- R5: In the command phase each 0xC4 write with bit 0 at 1 takes bit 1 as the next command bit, most significant first; the eighth such write completes the code.
- R6: Code 0x60 clears the line, direction and enable registers and returns to idle.
- R7: Code 0x63 returns the one-byte status; the status after reset is 0x40.
- R8: Code 0x67 returns three BCD bytes: hour, minute, second (tens digit in bits 7:4, units in bits 3:0).
- R9: Code 0x65 returns seven BCD bytes: year modulo 100, month plus 1, day, weekday (Sunday to 6, Monday..Saturday to 0..5), hour, minute, second.
- R10: While replying with direction bit 1 at 0, a 0xC4 write with bit 0 at 0 sets the line register to {8'h00, enable[7:2], reply bit, enable[0]}; reply bits go byte by byte, each byte least significant bit first. With direction bit 1 at 1 such writes do not drive or advance the reply.
- R11: A write with bit 0 at 1 advances the reply; after the last bit the line, direction and enable registers read 0 and the block is idle.
- R12: Code 0x62 with direction bit 1 at 1 accepts a byte: writes with bit 0 at 0 sample bit 1 most significant first, writes with bit 0 at 1 count bits, and the eighth count stores the byte as the new status.
- R13: An unrecognised code leaves the command phase open with the counter at 0, so one more clock-high write ORs bit 1 into bit 0 of the code and completes it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register offset (0xC4 line, 0xC6 direction, 0xC8 enable) |
| wr_data | input | 16 | Write data |
| tm_year | input | 8 | Years since base year, binary |
| tm_mon0 | input | 4 | Month, 0-based |
| tm_mday | input | 5 | Day of month |
| tm_wday | input | 3 | Weekday, Sunday is 0 |
| tm_hour | input | 5 | Hour |
| tm_min | input | 6 | Minute |
| tm_sec | input | 6 | Second |
| rd_line | output | 16 | Line register readback |

## Verification
The hardest state to reach is the open command phase after an unknown code, because nothing on the readback changes when it happens. The stimulus sends 0x66, which the block does not know, and then one extra clock-high write with the data bit at 1; only if the block kept the phase open with its counter at 0 does the merged code become 0x67 and a three-byte time reply appear. A second subtle spot is a reply interrupted by a direction flip, which the stimulus inserts mid-byte before checking that the remaining bits still line up.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_IDLE = 3'd1,
    ST_CMD  = 3'd2,
    ST_TX   = 3'd3,
    ST_RX   = 3'd4
  } rtc_st_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_STAT = 2'd1,
    SRC_FULL = 2'd2,
    SRC_TIME = 2'd3
  } rtc_src_e;

  localparam logic [7:0] CODE_CLEAR    = 8'h60;
  localparam logic [7:0] CODE_SET_STAT = 8'h62;
  localparam logic [7:0] CODE_GET_STAT = 8'h63;
  localparam logic [7:0] CODE_DATETIME = 8'h65;
  localparam logic [7:0] CODE_TIME     = 8'h67;

  // binary 0..99 to two packed decimal digits
  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = v / 8'd10;
    units = v - tens * 8'd10;
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [7:0] year_two_digit(input logic [7:0] y);
    return y % 8'd100;
  endfunction

  // Sunday(0) -> 6, Monday..Saturday -> 0..5
  function automatic logic [7:0] wday_remap(input logic [2:0] d);
    return (d == 3'd0) ? 8'd6 : {5'd0, d - 3'd1};
  endfunction

endpackage

// File: rtl/rtc_time_bcd.sv
module rtc_time_bcd
  import rtc_serial_pkg::*;
#(
  parameter int BYTES_FULL  = 7,
  parameter int BYTES_SHORT = 3
) (
  input  logic [7:0]                 tm_year,
  input  logic [3:0]                 tm_mon0,
  input  logic [4:0]                 tm_mday,
  input  logic [2:0]                 tm_wday,
  input  logic [4:0]                 tm_hour,
  input  logic [5:0]                 tm_min,
  input  logic [5:0]                 tm_sec,
  output logic [8*BYTES_FULL-1:0]    full_vec,
  output logic [8*BYTES_SHORT-1:0]   short_vec
);
  logic [7:0] fields [BYTES_FULL];

  always_comb begin
    fields[0] = to_bcd(year_two_digit(tm_year));
    fields[1] = to_bcd({4'd0, tm_mon0} + 8'd1);
    fields[2] = to_bcd({3'd0, tm_mday});
    fields[3] = to_bcd(wday_remap(tm_wday));
    fields[4] = to_bcd({3'd0, tm_hour});
    fields[5] = to_bcd({2'd0, tm_min});
    fields[6] = to_bcd({2'd0, tm_sec});
  end

  // byte i of a reply sits at bits [8i+7:8i]
  for (genvar i = 0; i < BYTES_FULL; i++) begin : g_full
    assign full_vec[8*i +: 8] = fields[i];
  end
  for (genvar j = 0; j < BYTES_SHORT; j++) begin : g_short
    assign short_vec[8*j +: 8] = fields[BYTES_FULL - BYTES_SHORT + j];
  end
endmodule

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_serial_pkg::*;
(
  input  logic [7:0] code,
  output logic       known,
  output logic       clear_regs,
  output rtc_st_e    next_st,
  output logic [2:0] nbytes,
  output rtc_src_e   src
);
  always_comb begin
    known      = 1'b1;
    clear_regs = 1'b0;
    next_st    = ST_CMD;
    nbytes     = 3'd0;
    src        = SRC_NONE;
    unique case (code)
      CODE_CLEAR:    begin clear_regs = 1'b1; next_st = ST_IDLE; end
      CODE_SET_STAT: begin next_st = ST_RX; nbytes = 3'd1; end
      CODE_GET_STAT: begin next_st = ST_TX; nbytes = 3'd1; src = SRC_STAT; end
      CODE_DATETIME: begin next_st = ST_TX; nbytes = 3'd7; src = SRC_FULL; end
      CODE_TIME:     begin next_st = ST_TX; nbytes = 3'd3; src = SRC_TIME; end
      default:       known = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_tx_pick.sv
module rtc_tx_pick #(
  parameter int VEC_W = 56,
  parameter int IDX_W = 6
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_out
);
  localparam int PAD_W = 2 ** IDX_W;
  logic [PAD_W-1:0] padded;
  assign padded  = PAD_W'(vec);
  assign bit_out = padded[idx];
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rtc_serial_pkg::*;
#(
  parameter int          REG_W      = 16,
  parameter int          ADDR_W     = 8,
  parameter int          MAX_BYTES  = 7,
  parameter int          TIME_BYTES = 3,
  parameter logic [7:0]  OFF_LINE   = 8'hC4,
  parameter logic [7:0]  OFF_DIR    = 8'hC6,
  parameter logic [7:0]  OFF_EN     = 8'hC8,
  parameter logic [7:0]  STATUS_RST = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [7:0]        tm_year,
  input  logic [3:0]        tm_mon0,
  input  logic [4:0]        tm_mday,
  input  logic [2:0]        tm_wday,
  input  logic [4:0]        tm_hour,
  input  logic [5:0]        tm_min,
  input  logic [5:0]        tm_sec,
  output logic [REG_W-1:0]  rd_line
);
  localparam int BUF_W  = 8 * MAX_BYTES;
  localparam int CNT_W  = $clog2(BUF_W + 1);
  localparam int TIME_W = 8 * TIME_BYTES;

  rtc_st_e          state_q;
  logic [REG_W-1:0] line_q, dir_q, en_q;
  logic [7:0]       status_q, cmd_q, rxbuf_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       nbytes_q;
  logic [BUF_W-1:0] txbuf_q;

  // write decode
  logic hit_line, hit_dir, hit_en, path_on;
  assign hit_line = wr_en && (wr_addr == ADDR_W'(OFF_LINE));
  assign hit_dir  = wr_en && (wr_addr == ADDR_W'(OFF_DIR));
  assign hit_en   = wr_en && (wr_addr == ADDR_W'(OFF_EN));
  assign path_on  = en_q[0];

  rtc_st_e st_eff;
  assign st_eff = (state_q == ST_OFF) ? ST_IDLE : state_q;

  // select low freezes the data bit
  logic [REG_W-1:0] line_in;
  assign line_in = line_q[2] ? wr_data : {wr_data[REG_W-1:2], line_q[1], wr_data[0]};

  logic line_go;
  assign line_go = hit_line && path_on;

  // named events
  logic ev_start, cmd_clk, ev_cmd_done;
  logic tx_active, tx_drive, tx_step, ev_tx_end;
  logic rx_active, rx_capture, rx_step, ev_rx_end;

  assign ev_start = line_go && (st_eff == ST_IDLE) &&
                    (line_q == REG_W'(1)) && (line_in == REG_W'(5));

  assign cmd_clk     = line_go && !ev_start && (st_eff == ST_CMD) && line_in[0];
  assign ev_cmd_done = cmd_clk && (cnt_q == '0);

  logic [7:0] cmd_next;
  assign cmd_next = cmd_q | (8'(line_in[1]) << cnt_q[2:0]);

  logic [CNT_W-1:0] cnt_inc, tx_total;
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign tx_total = CNT_W'({nbytes_q, 3'b000});

  assign tx_active = line_go && !ev_start && (st_eff == ST_TX) && !dir_q[1];
  assign tx_drive  = tx_active && !line_in[0];
  assign tx_step   = tx_active && line_in[0];
  assign ev_tx_end = tx_step && (cnt_inc == tx_total);

  assign rx_active  = line_go && !ev_start && (st_eff == ST_RX) && dir_q[1];
  assign rx_capture = rx_active && !line_in[0];
  assign rx_step    = rx_active && line_in[0];
  assign ev_rx_end  = rx_step && (cnt_inc == CNT_W'(8));

  // command decode
  logic       dec_known, dec_clear;
  rtc_st_e    dec_next;
  logic [2:0] dec_nbytes;
  rtc_src_e   dec_src;

  rtc_cmd_decode u_dec (
    .code       (cmd_next),
    .known      (dec_known),
    .clear_regs (dec_clear),
    .next_st    (dec_next),
    .nbytes     (dec_nbytes),
    .src        (dec_src)
  );

  // time snapshot source
  logic [BUF_W-1:0]  full_vec;
  logic [TIME_W-1:0] short_vec;

  rtc_time_bcd #(.BYTES_FULL(MAX_BYTES), .BYTES_SHORT(TIME_BYTES)) u_bcd (
    .tm_year   (tm_year),
    .tm_mon0   (tm_mon0),
    .tm_mday   (tm_mday),
    .tm_wday   (tm_wday),
    .tm_hour   (tm_hour),
    .tm_min    (tm_min),
    .tm_sec    (tm_sec),
    .full_vec  (full_vec),
    .short_vec (short_vec)
  );

  logic [BUF_W-1:0] load_vec;
  always_comb begin
    unique case (dec_src)
      SRC_STAT: load_vec = BUF_W'(status_q);
      SRC_FULL: load_vec = full_vec;
      SRC_TIME: load_vec = BUF_W'(short_vec);
      default:  load_vec = '0;
    endcase
  end

  // reply bit
  logic tx_bit;
  rtc_tx_pick #(.VEC_W(BUF_W), .IDX_W(CNT_W)) u_pick (
    .vec     (txbuf_q),
    .idx     (cnt_q),
    .bit_out (tx_bit)
  );

  logic [REG_W-1:0] tx_word;
  assign tx_word = {{(REG_W-8){1'b0}}, en_q[7:2], tx_bit, en_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      line_q   <= '0;
      dir_q    <= '0;
      en_q     <= '0;
      status_q <= STATUS_RST;
      cmd_q    <= '0;
      rxbuf_q  <= '0;
      cnt_q    <= '0;
      nbytes_q <= '0;
      txbuf_q  <= '0;
    end else if (hit_line) begin
      if (state_q == ST_OFF) state_q <= ST_IDLE;
      if (path_on) begin
        line_q <= line_in;
        if (ev_start) begin
          state_q <= ST_CMD;
          cmd_q   <= '0;
          cnt_q   <= CNT_W'(7);
        end else if (cmd_clk) begin
          cmd_q <= cmd_next;
          if (ev_cmd_done) begin
            cnt_q <= '0;
            if (dec_clear) begin
              state_q <= ST_IDLE;
              line_q  <= '0;
              dir_q   <= '0;
              en_q    <= '0;
            end else if (dec_known) begin
              state_q  <= dec_next;
              nbytes_q <= dec_nbytes;
              txbuf_q  <= load_vec;
              rxbuf_q  <= '0;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end else if (tx_drive) begin
          line_q <= tx_word;
        end else if (tx_step) begin
          if (ev_tx_end) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            line_q  <= '0;
            dir_q   <= '0;
            en_q    <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end else if (rx_capture) begin
          rxbuf_q[3'd7 - cnt_q[2:0]] <= line_in[1];
        end else if (rx_step) begin
          if (ev_rx_end) begin
            state_q  <= ST_IDLE;
            status_q <= rxbuf_q;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
      end else begin
        en_q <= line_in;
      end
    end else if (hit_dir) begin
      dir_q <= wr_data;
    end else if (hit_en) begin
      en_q <= wr_data;
    end
  end

  assign rd_line = line_q;

endmodule

// File: rtl/rtc_serial_port_chk.sv
module rtc_serial_port_chk
  import rtc_serial_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input rtc_st_e          state_q,
  input logic [REG_W-1:0] line_q,
  input logic [REG_W-1:0] dir_q,
  input logic [REG_W-1:0] en_q,
  input logic [7:0]       status_q,
  input logic [7:0]       rxbuf_q,
  input logic [7:0]       cmd_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [2:0]       nbytes_q,
  input logic             hit_line,
  input logic             ev_start,
  input logic             ev_cmd_done,
  input logic             ev_tx_end,
  input logic             ev_rx_end,
  input logic             dec_known,
  input logic             dec_clear
);
  assert_wake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_line && state_q == ST_OFF) |=> (state_q != ST_OFF));

  assert_en_reroute_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_line && !en_q[0]) |=> $stable(line_q));

  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_line && en_q[0] && !line_q[2] && state_q == ST_IDLE)
      |=> (line_q[1] == $past(line_q[1])));

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state_q == ST_CMD && cnt_q == CNT_W'(7) && cmd_q == 8'h00));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && dec_clear)
      |=> (state_q == ST_IDLE && line_q == '0 && dir_q == '0 && en_q == '0));

  assert_tx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX) |-> (cnt_q < CNT_W'({nbytes_q, 3'b000})));

  assert_tx_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_end |=> (state_q == ST_IDLE && line_q == '0 && dir_q == '0 && en_q == '0));

  assert_rx_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_end |=> (state_q == ST_IDLE && status_q == $past(rxbuf_q)));

  assert_unknown_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && !dec_known) |=> (state_q == ST_CMD && cnt_q == '0));
endmodule

bind rtc_serial_port rtc_serial_port_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state_q     (state_q),
  .line_q      (line_q),
  .dir_q       (dir_q),
  .en_q        (en_q),
  .status_q    (status_q),
  .rxbuf_q     (rxbuf_q),
  .cmd_q       (cmd_q),
  .cnt_q       (cnt_q),
  .nbytes_q    (nbytes_q),
  .hit_line    (hit_line),
  .ev_start    (ev_start),
  .ev_cmd_done (ev_cmd_done),
  .ev_tx_end   (ev_tx_end),
  .ev_rx_end   (ev_rx_end),
  .dec_known   (dec_known),
  .dec_clear   (dec_clear)
);

// File: tb/rtc_serial_port_bench.sv
`timescale 1ns/1ps
module rtc_serial_port_bench;
  localparam int          CLK_NS = 20;
  localparam logic [7:0]  A_LINE = 8'hC4;
  localparam logic [7:0]  A_DIR  = 8'hC6;
  localparam logic [7:0]  A_EN   = 8'hC8;
  localparam logic [15:0] EN_VAL = 16'h0005;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  tm_year = '0;
  logic [3:0]  tm_mon0 = '0;
  logic [4:0]  tm_mday = '0;
  logic [2:0]  tm_wday = '0;
  logic [4:0]  tm_hour = '0;
  logic [5:0]  tm_min = '0;
  logic [5:0]  tm_sec = '0;
  logic [15:0] rd_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  rtc_serial_port u_rtc_serial_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tm_year(tm_year), .tm_mon0(tm_mon0), .tm_mday(tm_mday), .tm_wday(tm_wday),
    .tm_hour(tm_hour), .tm_min(tm_min), .tm_sec(tm_sec), .rd_line(rd_line)
  );

  typedef struct {
    logic [15:0] word;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  event bit_ev;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    int t = 0;
    while (v >= 10) begin v -= 10; t++; end
    return 8'((t << 4) | v);
  endfunction

  // monitor: compares each driven reply bit against the scoreboard
  initial begin
    forever begin
      @(bit_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected bit", rd_line, 16'hxxxx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rd_line == e.word, e.tag, rd_line, e.word);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b, input string tag);
    for (int i = 0; i < 8; i++) begin
      exp_t e;
      e.word = EN_VAL | (16'(b[i]) << 1);
      e.tag  = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic start_cmd(input logic [7:0] code);
    wr(A_EN, EN_VAL);
    wr(A_LINE, 16'h0004);
    wr(A_LINE, 16'h0001);
    wr(A_LINE, 16'h0005);
    chk(rd_line == 16'h0005, "R4 start handshake", rd_line, 16'h0005);
    for (int i = 7; i >= 0; i--) begin
      wr(A_LINE, 16'h0004 | (16'(code[i]) << 1));
      wr(A_LINE, 16'h0005 | (16'(code[i]) << 1));
    end
  endtask

  task automatic tx_one();
    wr(A_LINE, 16'h0004);
    -> bit_ev;
    wr(A_LINE, 16'h0005);
  endtask

  task automatic tx_bits(input int n);
    for (int k = 0; k < n; k++) tx_one();
  endtask

  task automatic rx_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wr(A_LINE, 16'h0004 | (16'(b[i]) << 1));
      wr(A_LINE, 16'h0005 | (16'(b[i]) << 1));
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_line == 16'h0000, "R1 reset line", rd_line, 16'h0000);

    // R2: enable clear, line write rerouted into enable
    wr(A_LINE, EN_VAL);
    chk(rd_line == 16'h0000, "R2 line untouched", rd_line, 16'h0000);
    wr(A_LINE, 16'h0004);
    chk(rd_line == 16'h0004, "R2 enable took value", rd_line, 16'h0004);

    // R3: select low holds data bit
    wr(A_LINE, 16'h0002);
    chk(rd_line == 16'h0002, "R3 select high passes", rd_line, 16'h0002);
    wr(A_LINE, 16'h0000);
    chk(rd_line == 16'h0002, "R3 bit1 held", rd_line, 16'h0002);
    wr(A_LINE, 16'h0004);
    chk(rd_line == 16'h0006, "R3 bit1 held again", rd_line, 16'h0006);

    // R7 R5: status after reset
    start_cmd(8'h63);
    push_byte(8'h40, "R7 R5 reset status");
    tx_bits(8);
    chk(rd_line == 16'h0000, "R11 cleared after status", rd_line, 16'h0000);

    // R8 with a direction flip in the middle (R10 ignored)
    tm_hour = 5'd9; tm_min = 6'd30; tm_sec = 6'd0;
    start_cmd(8'h67);
    tm_hour = 5'd1;
    push_byte(bcd(9), "R8 hour");
    push_byte(bcd(30), "R8 minute");
    push_byte(bcd(0), "R8 second");
    tx_bits(4);
    wr(A_DIR, 16'h0002);
    wr(A_LINE, 16'h0004);
    chk(rd_line == 16'h0004, "R10 direction high ignored", rd_line, 16'h0004);
    wr(A_LINE, 16'h0005);
    wr(A_DIR, 16'h0000);
    tx_bits(20);
    chk(rd_line == 16'h0000, "R11 cleared after time", rd_line, 16'h0000);

    // R9 sunday
    tm_year = 8'd124; tm_mon0 = 4'd10; tm_mday = 5'd7; tm_wday = 3'd0;
    tm_hour = 5'd23; tm_min = 6'd5; tm_sec = 6'd59;
    start_cmd(8'h65);
    push_byte(bcd(124 % 100), "R9 year");
    push_byte(bcd(11), "R9 month");
    push_byte(bcd(7), "R9 day");
    push_byte(bcd((0 + 6) % 7), "R9 weekday sunday");
    push_byte(bcd(23), "R9 hour");
    push_byte(bcd(5), "R9 minute");
    push_byte(bcd(59), "R9 second");
    tx_bits(56);
    chk(rd_line == 16'h0000, "R11 cleared after full", rd_line, 16'h0000);

    // R9 midweek, year wrap
    tm_year = 8'd199; tm_mon0 = 4'd0; tm_mday = 5'd31; tm_wday = 3'd3;
    tm_hour = 5'd0; tm_min = 6'd59; tm_sec = 6'd10;
    start_cmd(8'h65);
    push_byte(bcd(199 % 100), "R9 year wrap");
    push_byte(bcd(1), "R9 month first");
    push_byte(bcd(31), "R9 day");
    push_byte(bcd((3 + 6) % 7), "R9 weekday wed");
    push_byte(bcd(0), "R9 hour");
    push_byte(bcd(59), "R9 minute");
    push_byte(bcd(10), "R9 second");
    tx_bits(56);

    // R12 set status then read it back
    wr(A_EN, EN_VAL);
    wr(A_DIR, 16'h0002);
    start_cmd(8'h62);
    rx_byte(8'hA7);
    chk(rd_line == 16'h0007, "R12 regs kept after input", rd_line, 16'h0007);
    wr(A_DIR, 16'h0000);
    start_cmd(8'h63);
    push_byte(8'hA7, "R12 new status");
    tx_bits(8);

    // R6 clear command
    wr(A_DIR, 16'h0002);
    start_cmd(8'h60);
    chk(rd_line == 16'h0000, "R6 line cleared", rd_line, 16'h0000);
    wr(A_LINE, 16'h0004);
    chk(rd_line == 16'h0000, "R6 enable cleared", rd_line, 16'h0000);
    wr(A_DIR, 16'h0000);

    // R13 unknown code, then one more clock-high bit
    tm_hour = 5'd12; tm_min = 6'd34; tm_sec = 6'd56;
    start_cmd(8'h66);
    chk(rd_line == 16'h0005, "R13 no reply yet", rd_line, 16'h0005);
    wr(A_LINE, 16'h0007);
    push_byte(bcd(12), "R13 merged hour");
    push_byte(bcd(34), "R13 merged minute");
    push_byte(bcd(56), "R13 merged second");
    tx_bits(24);
    chk(rd_line == 16'h0000, "R13 reply complete", rd_line, 16'h0000);

    @(negedge clk);
    chk(exp_q.size() == 0, "R10 scoreboard drained", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule